// File: doc/BRIEF.md
# Burst-Counter Synchronous Memory Port

This block is one fully synchronous access port onto a banked static memory. Every input is captured on the rising clock edge: the word address, a 6-bit bank select, the read/write strobe, two byte enables, two chip enables, output enable and three counter controls. The access itself happens one edge later, against an address taken from an internal burst counter. On each cycle that counter can take a fresh external address, step to the next word, keep its value, or return to the address it last took from outside.

Read data can leave the port on one of two latencies. In flow-through mode the word read for a command is presented right after the access edge. In pipelined mode it passes through one more register and appears one clock later. A static mode input selects the latency. The storage is a behavioural array that is kept small by parameter. Only the low bits of the bank and word addresses index it, so higher addresses alias onto it.

Top module: `burst_sram_port`

## Requirements
- R1: A location is named by a 6-bit bank (`bank_in`) and a 13-bit word (`word_in`). With the default storage size, only bank bits 1:0 and word bits 3:0 select the stored entry, so for example bank 5 word 18 reaches the same entry as bank 1 word 2.
- R2: Every input is registered on the rising edge. In flow-through mode, a read captured at edge N is not yet valid after edge N and presents its data after edge N+1.
- R3: When `addr_ld_n` is low, the counter takes `bank_in`/`word_in`, that cycle's access uses this address, and the address is remembered as the last loaded address.
- R4: When `addr_ld_n` and `rpt_n` are high and `cnt_en_n` is low, the access address is the word after the previous cycle's address.
- R5: When `addr_ld_n`, `rpt_n` and `cnt_en_n` are all high, the address is held, so successive selected reads return the same data.
- R6: When `rpt_n` is low and `addr_ld_n` is high, the access uses the last loaded address, even if `cnt_en_n` is also low. When `addr_ld_n` and `rpt_n` are both low, the new external address is loaded.
- R7: Stepping from word 8191 goes to word 0 of the same bank. The counter never changes the bank.
- R8: The port is selected only when `sel0_n` is low and `sel1` is high. A deselected write leaves memory unchanged, and a deselected read gives `rdata_vld` low.
- R9: `rd_wr_n` high reads and low writes. `hi_en_n` low writes bits 17:9 and `lo_en_n` low writes bits 8:0. A write with both enables high changes nothing, and a write cycle never raises `rdata_vld`.
- R10: With `pipe_mode` high, read data and its valid flag appear exactly one clock later than with `pipe_mode` low.
- R11: When the registered `oe_n` is high, `rdata_vld` is low (the output is treated as undriven).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through (static) |
| addr_ld_n | input | 1 | Active-low load of the external address |
| cnt_en_n | input | 1 | Active-low counter step |
| rpt_n | input | 1 | Active-low return to last loaded address |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| sel0_n | input | 1 | Active-low chip enable |
| sel1 | input | 1 | Active-high chip enable |
| hi_en_n | input | 1 | Active-low enable for bits 17:9 |
| lo_en_n | input | 1 | Active-low enable for bits 8:0 |
| oe_n | input | 1 | Active-low output enable |
| bank_in | input | 6 | Bank address |
| word_in | input | 13 | Word address within the bank |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Read data |
| rdata_vld | output | 1 | Read data driven and valid |

## Verification
The hardest state to reach is the word-address wrap. It needs the counter to be sitting at the top word of a bank while the ports show nothing but data. The stimulus loads word 8191 of bank 1 directly and then steps twice. It expects the entries stored at words 15 and 0 of bank 1, not the entry of bank 2, which a carry into the bank field would select. The repeat cases use a similar approach. A load is issued with repeat also low, so the remembered address changes, and a later repeat must return to that new address and not the old one.

// File: rtl/burst_port_pkg.sv
package burst_port_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_ADV  = 2'd1,
        CNT_RPT  = 2'd2,
        CNT_LOAD = 2'd3
    } cnt_op_e;

    // Priority: external load, then repeat, then step, else hold.
    function automatic cnt_op_e pick_op(input logic ld_n, input logic rp_n, input logic st_n);
        if (!ld_n)      return CNT_LOAD;
        else if (!rp_n) return CNT_RPT;
        else if (!st_n) return CNT_ADV;
        return CNT_HOLD;
    endfunction

endpackage

// File: rtl/bsp_in_reg.sv
module bsp_in_reg #(
    parameter int         W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap_in,
    output logic [W-1:0] cap_q
);
    logic [W-1:0] cap_d;

    always_comb begin
        cap_d = cap_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= RST_VAL;
        else        cap_q <= cap_d;
    end
endmodule

// File: rtl/bsp_addr_ctr.sv
module bsp_addr_ctr
    import burst_port_pkg::*;
#(
    parameter int BANK_W = 6,
    parameter int WORD_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cnt_op_e           op,
    input  logic [BANK_W-1:0] ld_bank,
    input  logic [WORD_W-1:0] ld_word,
    output logic [BANK_W-1:0] acc_bank,
    output logic [WORD_W-1:0] acc_word
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [WORD_W-1:0] word;
        logic [BANK_W-1:0] mark_bank;
        logic [WORD_W-1:0] mark_word;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            CNT_LOAD: begin
                st_d.bank      = ld_bank;
                st_d.word      = ld_word;
                st_d.mark_bank = ld_bank;
                st_d.mark_word = ld_word;
            end
            CNT_RPT: begin
                st_d.bank = st_q.mark_bank;
                st_d.word = st_q.mark_word;
            end
            CNT_ADV:  st_d.word = st_q.word + WORD_W'(1);
            default:  ;
        endcase
        acc_bank = st_d.bank;
        acc_word = st_d.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_LOAD) |=> (st_q.word == $past(ld_word) && st_q.bank == $past(ld_bank)));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_ADV) |=> (st_q.word == $past(st_q.word) + WORD_W'(1)));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_HOLD) |=> ($stable(st_q.word) && $stable(st_q.bank)));
    p_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_RPT) |=> (st_q.word == $past(st_q.mark_word) && st_q.bank == $past(st_q.mark_bank)));
    p_bank_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_ADV) |=> $stable(st_q.bank));
endmodule

// File: rtl/bsp_mem_core.sv
module bsp_mem_core #(
    parameter int DATA_W        = 18,
    parameter int MEM_BANK_BITS = 2,
    parameter int MEM_WORD_BITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_en,
    input  logic                     wr,
    input  logic                     hi_n,
    input  logic                     lo_n,
    input  logic [MEM_BANK_BITS-1:0] bank,
    input  logic [MEM_WORD_BITS-1:0] word,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        f_data,
    output logic                     f_vld
);
    localparam int IDX_W = MEM_BANK_BITS + MEM_WORD_BITS;
    localparam int DEPTH = 1 << IDX_W;
    localparam int HALF  = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } rd_t;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;
    rd_t               st_d, st_q;

    assign idx = {bank, word};

    always_ff @(posedge clk) begin
        if (acc_en && wr) begin
            if (!hi_n) mem[idx][DATA_W-1:HALF] <= wdata[DATA_W-1:HALF];
            if (!lo_n) mem[idx][HALF-1:0]      <= wdata[HALF-1:0];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = acc_en && !wr;
        if (st_d.vld) st_d.data = mem[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign f_data = st_q.data;
    assign f_vld  = st_q.vld;

    p_desel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !f_vld);
    p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wr) |=> !f_vld);
endmodule

// File: rtl/bsp_rd_lat.sv
module bsp_rd_lat #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              oe_n_q,
    input  logic [DATA_W-1:0] f_data,
    input  logic              f_vld,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } stg_t;

    stg_t st_d, st_q;

    always_comb begin
        st_d.data = f_data;
        st_d.vld  = f_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata     = pipe_mode ? st_q.data : f_data;
        rdata_vld = (pipe_mode ? st_q.vld : f_vld) && !oe_n_q;
    end

    p_extra_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(f_vld));
endmodule

// File: rtl/burst_sram_port.sv
module burst_sram_port
    import burst_port_pkg::*;
#(
    parameter int BANK_W        = 6,
    parameter int WORD_W        = 13,
    parameter int DATA_W        = 18,
    parameter int MEM_BANK_BITS = 2,
    parameter int MEM_WORD_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              addr_ld_n,
    input  logic              cnt_en_n,
    input  logic              rpt_n,
    input  logic              rd_wr_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              hi_en_n,
    input  logic              lo_en_n,
    input  logic              oe_n,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [WORD_W-1:0] word_in,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);
    localparam int CTL_W = 9;
    localparam int CAP_W = CTL_W + BANK_W + WORD_W + DATA_W;
    localparam logic [CAP_W-1:0] CAP_RST = {9'b111110111, {(CAP_W-CTL_W){1'b0}}};

    logic [CAP_W-1:0]  cap_in, cap_q;
    logic              ld_n_q, step_n_q, rpt_n_q, rd_q, sel0_n_q, sel1_q;
    logic              hi_n_q, lo_n_q, oe_n_q;
    logic [BANK_W-1:0] bank_q, acc_bank;
    logic [WORD_W-1:0] word_q, acc_word;
    logic [DATA_W-1:0] wdata_q, f_data;
    logic              f_vld, selected;
    logic              unused_addr_bits;
    cnt_op_e           op;

    assign cap_in = {addr_ld_n, cnt_en_n, rpt_n, rd_wr_n, sel0_n, sel1,
                     hi_en_n, lo_en_n, oe_n, bank_in, word_in, wdata};

    bsp_in_reg #(.W(CAP_W), .RST_VAL(CAP_RST)) u_in (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .cap_q(cap_q)
    );

    assign {ld_n_q, step_n_q, rpt_n_q, rd_q, sel0_n_q, sel1_q,
            hi_n_q, lo_n_q, oe_n_q, bank_q, word_q, wdata_q} = cap_q;

    assign op       = pick_op(ld_n_q, rpt_n_q, step_n_q);
    assign selected = !sel0_n_q && sel1_q;

    bsp_addr_ctr #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .op(op),
        .ld_bank(bank_q), .ld_word(word_q),
        .acc_bank(acc_bank), .acc_word(acc_word)
    );

    assign unused_addr_bits = ^{acc_bank, acc_word};

    bsp_mem_core #(
        .DATA_W(DATA_W), .MEM_BANK_BITS(MEM_BANK_BITS), .MEM_WORD_BITS(MEM_WORD_BITS)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .acc_en(selected), .wr(!rd_q),
        .hi_n(hi_n_q), .lo_n(lo_n_q),
        .bank(acc_bank[MEM_BANK_BITS-1:0]), .word(acc_word[MEM_WORD_BITS-1:0]),
        .wdata(wdata_q), .f_data(f_data), .f_vld(f_vld)
    );

    bsp_rd_lat #(.DATA_W(DATA_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe_n_q(oe_n_q),
        .f_data(f_data), .f_vld(f_vld), .rdata(rdata), .rdata_vld(rdata_vld)
    );
endmodule

// File: tb/burst_sram_port_tb.sv
module burst_sram_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pipe_mode = 1'b0;
    logic        addr_ld_n, cnt_en_n, rpt_n, rd_wr_n, sel0_n, sel1, hi_en_n, lo_en_n, oe_n;
    logic [5:0]  bank_in = '0;
    logic [12:0] word_in = '0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic        rdata_vld;

    int n_chk = 0;
    int n_bad = 0;

    logic [17:0] model [64];
    int op_s [16];
    int bk_s [16];
    int wd_s [16];
    int seq_n;

    always #5 clk = ~clk;

    burst_sram_port u_dut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
        .addr_ld_n(addr_ld_n), .cnt_en_n(cnt_en_n), .rpt_n(rpt_n), .rd_wr_n(rd_wr_n),
        .sel0_n(sel0_n), .sel1(sel1), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .oe_n(oe_n),
        .bank_in(bank_in), .word_in(word_in), .wdata(wdata),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    function automatic logic [17:0] pat(int b, int w);
        return 18'((b * 16 + w) * 1021 + 7);
    endfunction

    function automatic int ix(int b, int w);
        return (b % 4) * 16 + (w % 16);
    endfunction

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(string rq, logic [17:0] act, logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        addr_ld_n = 1; cnt_en_n = 1; rpt_n = 1; rd_wr_n = 1;
        sel0_n = 1; sel1 = 1; hi_en_n = 0; lo_en_n = 0; oe_n = 0;
    endtask

    task automatic wr_word(int b, int w, logic [17:0] d, logic hn, logic ln, logic s0n, logic s1);
        addr_ld_n = 0; rd_wr_n = 0; bank_in = 6'(b); word_in = 13'(w); wdata = d;
        hi_en_n = hn; lo_en_n = ln; sel0_n = s0n; sel1 = s1;
        if (!s0n && s1) begin
            if (!hn) model[ix(b, w)][17:9] = d[17:9];
            if (!ln) model[ix(b, w)][8:0]  = d[8:0];
        end
        cyc();
        idle();
    endtask

    task automatic rd_single(string rq, int b, int w);
        addr_ld_n = 0; rd_wr_n = 1; sel0_n = 0; sel1 = 1;
        bank_in = 6'(b); word_in = 13'(w);
        cyc();
        idle();
        if (!pipe_mode) chk({rq, " R2 not yet valid"}, {17'b0, rdata_vld}, 18'd0);
        cyc();
        if (pipe_mode) cyc();
        chk({rq, " valid"}, {17'b0, rdata_vld}, 18'd1);
        chk({rq, " data"}, rdata, model[ix(b, w)]);
        cyc();
    endtask

    // ops: 0 load, 1 step, 2 hold, 3 repeat(+step low), 4 load with repeat and step low
    task automatic add(int op, int b, int w);
        op_s[seq_n] = op; bk_s[seq_n] = b; wd_s[seq_n] = w;
        seq_n++;
    endtask

    task automatic run_seq(string rq);
        logic [17:0] exp_s [16];
        int cur_b = 0, cur_w = 0, mk_b = 0, mk_w = 0;
        int pm = pipe_mode ? 1 : 0;
        for (int i = 0; i < seq_n; i++) begin
            if (op_s[i] == 0 || op_s[i] == 4) begin
                cur_b = bk_s[i]; cur_w = wd_s[i]; mk_b = cur_b; mk_w = cur_w;
            end else if (op_s[i] == 3) begin
                cur_b = mk_b; cur_w = mk_w;
            end else if (op_s[i] == 1) begin
                cur_w = (cur_w + 1) % 8192;
            end
            exp_s[i] = model[ix(cur_b, cur_w)];
        end
        idle();
        cyc(); cyc();
        for (int i = 0; i < seq_n + 1 + pm; i++) begin
            if (i < seq_n) begin
                sel0_n = 0; sel1 = 1; rd_wr_n = 1; oe_n = 0;
                bank_in = 6'(bk_s[i]); word_in = 13'(wd_s[i]);
                addr_ld_n = !(op_s[i] == 0 || op_s[i] == 4);
                rpt_n     = !(op_s[i] == 3 || op_s[i] == 4);
                cnt_en_n  = !(op_s[i] == 1 || op_s[i] == 3 || op_s[i] == 4);
            end else begin
                idle();
            end
            cyc();
            if (pm == 1 && i == 1)
                chk({rq, " R10 extra cycle"}, {17'b0, rdata_vld}, 18'd0);
            if (i >= 1 + pm) begin
                chk({rq, " valid"}, {17'b0, rdata_vld}, 18'd1);
                chk({rq, " data"}, rdata, exp_s[i - 1 - pm]);
            end
        end
        seq_n = 0;
        cyc();
    endtask

    task automatic t_reset();
        chk("R8 reset valid low", {17'b0, rdata_vld}, 18'd0);
    endtask

    task automatic t_fill();
        for (int b = 0; b < 4; b++)
            for (int w = 0; w < 16; w++)
                wr_word(b, w, pat(b, w), 1'b0, 1'b0, 1'b0, 1'b1);
        cyc();
        rd_single("R9 read back", 2, 9);
        rd_single("R1 bank alias", 5, 3);
        rd_single("R1 word alias", 1, 18);
    endtask

    task automatic t_burst();
        seq_n = 0;
        add(0, 1, 3); add(1, 0, 0); add(1, 0, 0); add(2, 0, 0); add(2, 0, 0); add(1, 0, 0);
        run_seq("R3 R4 R5 burst");
    endtask

    task automatic t_repeat();
        seq_n = 0;
        add(0, 2, 7); add(1, 0, 0); add(1, 0, 0); add(3, 0, 0); add(1, 0, 0);
        add(4, 2, 12); add(1, 0, 0); add(3, 0, 0);
        run_seq("R6 repeat");
    endtask

    task automatic t_wrap();
        seq_n = 0;
        add(0, 1, 8191); add(1, 0, 0); add(1, 0, 0);
        run_seq("R7 wrap");
    endtask

    task automatic t_pipe();
        pipe_mode = 1'b1;
        seq_n = 0;
        add(0, 3, 2); add(1, 0, 0); add(2, 0, 0); add(1, 0, 0);
        run_seq("R10 pipelined");
        rd_single("R10 single", 0, 11);
        pipe_mode = 1'b0;
        cyc(); cyc();
    endtask

    task automatic t_bytes();
        wr_word(0, 5, 18'h3FFFF, 1'b0, 1'b1, 1'b0, 1'b1);
        wr_word(0, 6, 18'h3FFFF, 1'b1, 1'b0, 1'b0, 1'b1);
        wr_word(0, 7, 18'h3FFFF, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc();
        rd_single("R9 upper only", 0, 5);
        chk("R9 upper bits", rdata, {9'h1FF, pat(0, 5)[8:0]});
        rd_single("R9 lower only", 0, 6);
        rd_single("R9 no enables", 0, 7);
        chk("R9 unchanged", rdata, pat(0, 7));
    endtask

    task automatic t_select();
        wr_word(3, 1, 18'h15555, 1'b0, 1'b0, 1'b1, 1'b1);
        wr_word(3, 1, 18'h2AAAA, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc();
        rd_single("R8 deselected writes", 3, 1);
        chk("R8 entry kept", rdata, pat(3, 1));
        addr_ld_n = 0; rd_wr_n = 1; sel0_n = 0; sel1 = 0; bank_in = 6'd3; word_in = 13'd1;
        cyc(); idle(); cyc();
        chk("R8 deselected read", {17'b0, rdata_vld}, 18'd0);
        cyc();
    endtask

    task automatic t_oe();
        addr_ld_n = 0; rd_wr_n = 1; sel0_n = 0; sel1 = 1; oe_n = 1;
        bank_in = 6'd2; word_in = 13'd4;
        cyc();
        addr_ld_n = 1; oe_n = 1;
        cyc();
        chk("R11 output disabled", {17'b0, rdata_vld}, 18'd0);
        oe_n = 0;
        cyc();
        chk("R11 output enabled", {17'b0, rdata_vld}, 18'd1);
        chk("R11 data", rdata, pat(2, 4));
        idle();
        cyc();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_fill();
        t_burst();
        t_repeat();
        t_wrap();
        t_pipe();
        t_bytes();
        t_select();
        t_oe();
        report();
    end
endmodule